// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block drives the command line of an SD or MMC card. A host presents a command word and a 32-bit argument with a one-cycle valid strobe. The engine builds a 48-bit command frame and protects it with a CRC7. It shifts the frame out one bit per card clock cycle. If the command word asks for a reply, the engine then waits for the card's start bit. It deserialises a 48-bit or 136-bit response and checks the CRC and the end bit.

Each command ends in exactly one single-cycle status pulse. The last captured response stays on the response index and word outputs until the next capture. Flags in the command word choose three things: holding the frame until an external pend input rises, replacing the response timer with a wait for an external interrupt input, and watching DAT0 for busy after a good response. Clock division and the data lines are handled elsewhere. Here `clk_i` is the card clock.

Command word bits are: [5:0] index, 6 response expected, 7 long response, 8 interrupt wait (no timer), 9 wait for pend, 10 enable, 11 busy watch.

Top module: `sdcmd_engine`

## Requirements
- R1: A command starts only on `cmd_valid_i` with word bit 10 set while the engine is idle. A strobe with bit 10 clear, or any strobe while `active_o` is high, has no effect.
- R2: The transmitted frame is, MSB first: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, then a CRC7 (x^7+x^3+1, zero seed) over those 40 bits, then a 1 end bit. `cmd_oe_o` is high for exactly these 48 cycles.
- R3: With word bit 6 clear, `sent_o` pulses in the cycle after the end bit leaves.
- R4: A short response has the layout {0, 0, index[5:0], status[31:0], crc[6:0], 1}. It sets `resp_idx_o` to its index and `resp0_o` to its status, and clears the other words. If its CRC over the first 40 bits matches and its end bit is 1, `resp_end_o` pulses.
- R5: With word bit 7 set, a 136-bit response is captured. `resp_idx_o` takes bits 133:128, `resp0_o`..`resp3_o` take bits 127:0 MSB-word first, and bit 0 of `resp3_o` reads 0. The CRC is computed over bits 127:8 and compared with bits 7:1.
- R6: A CRC mismatch or an end bit of 0 pulses `crc_fail_o` instead of `resp_end_o`.
- R7: If no start bit (0) is seen in the 64 cycles that follow the end bit, `timeout_o` pulses. A start bit in the 64th cycle is still accepted.
- R8: With word bit 9 set, nothing is driven until `pend_i` is high. The frame then follows.
- R9: With word bit 8 set, there is no timeout. The engine waits for a start bit, or for `irq_i`, which ends the command with `irq_end_o`.
- R10: With word bit 11 set, a good response is followed by a busy watch. `prog_done_o` pulses the cycle after `dat0_i` is seen high, and not before.
- R11: At most one status pulse is high in any cycle. `active_o` is high from the start of a command until the cycle of its final pulse, where it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | card clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cmd_valid_i | input | 1 | command word and argument valid |
| cmd_word_i | input | 12 | command index and flags |
| cmd_arg_i | input | 32 | command argument |
| pend_i | input | 1 | release for a held frame |
| irq_i | input | 1 | interrupt ending an untimed wait |
| cmd_in_i | input | 1 | command line as driven by the card |
| dat0_i | input | 1 | DAT0 level, low while the card is busy |
| cmd_out_o | output | 1 | command line output bit |
| cmd_oe_o | output | 1 | command line output enable |
| active_o | output | 1 | command in progress |
| sent_o | output | 1 | pulse: frame sent, no response |
| resp_end_o | output | 1 | pulse: good response |
| crc_fail_o | output | 1 | pulse: bad response CRC or end bit |
| timeout_o | output | 1 | pulse: no response start |
| irq_end_o | output | 1 | pulse: interrupt ended wait |
| prog_done_o | output | 1 | pulse: busy released |
| resp_idx_o | output | 6 | returned index field |
| resp0_o | output | 32 | response word 0 |
| resp1_o | output | 32 | response word 1 |
| resp2_o | output | 32 | response word 2 |
| resp3_o | output | 32 | response word 3 |

## Verification
The assertions check every cycle that status pulses are mutually exclusive and that `active_o` drops with each final pulse. They also check that the output frame opens with a 0 and closes with a 1, that a held frame leaves only with pend high, and that no timeout fires in interrupt mode. Only the bench scenarios can show the frame contents and CRC bit for bit, and the exact 64-cycle timeout boundary. The same holds for the field placement of short and long responses, the CRC and end-bit failure paths, and the order of response end and program done around the busy release.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int CW_W      = 12;
  localparam int IDX_W     = 6;
  localparam int ARG_W     = 32;
  localparam int HEAD_W    = 2 + IDX_W + ARG_W;
  localparam int SHORT_LEN = HEAD_W + 8;
  localparam int LONG_LEN  = 136;
  localparam int CAP_W     = LONG_LEN - 2;

  localparam int CW_RESP = 6;
  localparam int CW_LONG = 7;
  localparam int CW_IRQ  = 8;
  localparam int CW_PEND = 9;
  localparam int CW_EN   = 10;
  localparam int CW_PROG = 11;

  typedef enum logic [2:0] {
    S_IDLE, S_PEND, S_TX, S_WAIT, S_RX, S_BUSY
  } sdcmd_state_e;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  logic fb;
  assign fb = bit_i ^ crc_o[6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= '0;
    else if (clr_i)  crc_o <= '0;
    else if (en_i)   crc_o <= {crc_o[5:3], crc_o[2] ^ fb, crc_o[1:0], fb};
  end
endmodule

// File: rtl/sdcmd_rx_cap.sv
module sdcmd_rx_cap
  import sdcmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             cap_i,
  input  logic             long_i,
  input  logic             bit_i,
  output logic [7:0]       tail_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [31:0]      w0_o,
  output logic [31:0]      w1_o,
  output logic [31:0]      w2_o,
  output logic [31:0]      w3_o
);
  logic [CAP_W-2:0] sh_q;
  logic [CAP_W-1:0] full;

  assign full   = {sh_q, bit_i};
  assign tail_o = full[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (clr_i)    sh_q <= '0;  // start bit already seen as 0
    else if (shift_i)  sh_q <= full[CAP_W-2:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o <= '0; w0_o <= '0; w1_o <= '0; w2_o <= '0; w3_o <= '0;
    end else if (cap_i) begin
      if (long_i) begin
        idx_o <= full[133:128];
        w0_o  <= full[127:96];
        w1_o  <= full[95:64];
        w2_o  <= full[63:32];
        w3_o  <= {full[31:1], 1'b0};
      end else begin
        idx_o <= full[45:40];
        w0_o  <= full[39:8];
        w1_o  <= '0;
        w2_o  <= '0;
        w3_o  <= '0;
      end
    end
  end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CW_W-1:0]  cmd_word_i,
  input  logic [ARG_W-1:0] cmd_arg_i,
  input  logic             pend_i,
  input  logic             irq_i,
  input  logic             cmd_in_i,
  input  logic             dat0_i,
  output logic             cmd_out_o,
  output logic             cmd_oe_o,
  output logic             active_o,
  output logic             sent_o,
  output logic             resp_end_o,
  output logic             crc_fail_o,
  output logic             timeout_o,
  output logic             irq_end_o,
  output logic             prog_done_o,
  output logic [IDX_W-1:0] resp_idx_o,
  output logic [31:0]      resp0_o,
  output logic [31:0]      resp1_o,
  output logic [31:0]      resp2_o,
  output logic [31:0]      resp3_o
);
  localparam int TW = $clog2(TIMEOUT_CYC) + 1;
  localparam logic [7:0] TX_LAST = 8'(SHORT_LEN - 1);
  localparam logic [7:0] CRC_END = 8'(HEAD_W);

  sdcmd_state_e     state_q;
  logic [CW_W-1:0]  word_q;
  logic [ARG_W-1:0] arg_q;
  logic [7:0]       bcnt_q;
  logic [TW-1:0]    tcnt_q;
  logic [HEAD_W-1:0] head;
  logic [7:0]       hsel, csel;
  logic             tx_bit;
  logic [6:0]       tx_crc, rx_crc;
  logic             rx_crc_en, rx_last, rx_ok, rx_start;
  logic [7:0]       tail;

  assign head = {1'b0, 1'b1, word_q[IDX_W-1:0], arg_q};
  assign hsel = 8'(HEAD_W - 1) - bcnt_q;
  assign csel = 8'(SHORT_LEN - 2) - bcnt_q;

  always_comb begin
    if (bcnt_q < CRC_END)       tx_bit = head[hsel[5:0]];
    else if (bcnt_q < TX_LAST)  tx_bit = tx_crc[csel[2:0]];
    else                        tx_bit = 1'b1;
  end

  assign cmd_oe_o  = (state_q == S_TX);
  assign cmd_out_o = cmd_oe_o ? tx_bit : 1'b1;
  assign active_o  = (state_q != S_IDLE);

  sdcmd_crc7 u_tx_crc (
    .clk_i, .rst_ni,
    .clr_i (state_q != S_TX),
    .en_i  (state_q == S_TX && bcnt_q < CRC_END),
    .bit_i (tx_bit),
    .crc_o (tx_crc)
  );

  assign rx_start  = (state_q == S_WAIT) && !cmd_in_i;
  assign rx_last   = (state_q == S_RX) &&
                     (bcnt_q == (word_q[CW_LONG] ? 8'(LONG_LEN - 1) : TX_LAST));
  assign rx_crc_en = (state_q == S_RX) &&
                     (word_q[CW_LONG] ? (bcnt_q >= 8'd8 && bcnt_q < 8'd128)
                                      : (bcnt_q < CRC_END));

  sdcmd_crc7 u_rx_crc (
    .clk_i, .rst_ni,
    .clr_i (state_q != S_RX),
    .en_i  (rx_crc_en),
    .bit_i (cmd_in_i),
    .crc_o (rx_crc)
  );

  sdcmd_rx_cap u_cap (
    .clk_i, .rst_ni,
    .clr_i   (rx_start),
    .shift_i (state_q == S_RX),
    .cap_i   (rx_last),
    .long_i  (word_q[CW_LONG]),
    .bit_i   (cmd_in_i),
    .tail_o  (tail),
    .idx_o   (resp_idx_o),
    .w0_o    (resp0_o),
    .w1_o    (resp1_o),
    .w2_o    (resp2_o),
    .w3_o    (resp3_o)
  );

  assign rx_ok = (rx_crc == tail[7:1]) && tail[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      word_q  <= '0;
      arg_q   <= '0;
      bcnt_q  <= '0;
      tcnt_q  <= '0;
      sent_o <= 1'b0; resp_end_o <= 1'b0; crc_fail_o <= 1'b0;
      timeout_o <= 1'b0; irq_end_o <= 1'b0; prog_done_o <= 1'b0;
    end else begin
      sent_o <= 1'b0; resp_end_o <= 1'b0; crc_fail_o <= 1'b0;
      timeout_o <= 1'b0; irq_end_o <= 1'b0; prog_done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cmd_valid_i && cmd_word_i[CW_EN]) begin
          word_q  <= cmd_word_i;
          arg_q   <= cmd_arg_i;
          bcnt_q  <= '0;
          state_q <= cmd_word_i[CW_PEND] ? S_PEND : S_TX;
        end
        S_PEND: if (pend_i) state_q <= S_TX;
        S_TX: begin
          bcnt_q <= bcnt_q + 8'd1;
          if (bcnt_q == TX_LAST) begin
            tcnt_q <= '0;
            if (word_q[CW_RESP]) state_q <= S_WAIT;
            else begin
              sent_o  <= 1'b1;
              state_q <= S_IDLE;
            end
          end
        end
        S_WAIT: begin
          if (!cmd_in_i) begin
            bcnt_q  <= 8'd1;
            state_q <= S_RX;
          end else if (word_q[CW_IRQ]) begin
            if (irq_i) begin
              irq_end_o <= 1'b1;
              state_q   <= S_IDLE;
            end
          end else if (tcnt_q == TW'(TIMEOUT_CYC - 1)) begin
            timeout_o <= 1'b1;
            state_q   <= S_IDLE;
          end else begin
            tcnt_q <= tcnt_q + TW'(1);
          end
        end
        S_RX: begin
          bcnt_q <= bcnt_q + 8'd1;
          if (rx_last) begin
            if (!rx_ok) begin
              crc_fail_o <= 1'b1;
              state_q    <= S_IDLE;
            end else begin
              resp_end_o <= 1'b1;
              state_q    <= word_q[CW_PROG] ? S_BUSY : S_IDLE;
            end
          end
        end
        S_BUSY: if (dat0_i) begin
          prog_done_o <= 1'b1;
          state_q     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic [5:0] pulses;
  assign pulses = {sent_o, resp_end_o, crc_fail_o, timeout_o, irq_end_o, prog_done_o};

  p_one_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pulses));
  p_final_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sent_o || crc_fail_o || timeout_o || irq_end_o || prog_done_o) |-> (!active_o && $past(active_o)));
  p_oe_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_oe_o |-> active_o);
  p_start_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_oe_o) |-> !cmd_out_o);
  p_end_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_oe_o) |-> $past(cmd_out_o));
  p_pend_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == S_PEND && state_q == S_TX) |-> $past(pend_i));
  p_no_timer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !word_q[CW_IRQ]);
endmodule

// File: tb/sdcmd_engine_tb_top.sv
module sdcmd_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [11:0] cmd_word = '0;
  logic [31:0] cmd_arg = '0;
  logic pend = 1'b0, irq = 1'b0, cmd_in = 1'b1, dat0 = 1'b1;
  logic cmd_out, cmd_oe, active;
  logic sent, resp_end, crc_fail, tmo, irq_end, prog_done;
  logic [5:0] resp_idx;
  logic [31:0] r0, r1, r2, r3;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sdcmd_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .cmd_arg_i(cmd_arg), .pend_i(pend), .irq_i(irq), .cmd_in_i(cmd_in), .dat0_i(dat0),
    .cmd_out_o(cmd_out), .cmd_oe_o(cmd_oe), .active_o(active), .sent_o(sent),
    .resp_end_o(resp_end), .crc_fail_o(crc_fail), .timeout_o(tmo), .irq_end_o(irq_end),
    .prog_done_o(prog_done), .resp_idx_o(resp_idx), .resp0_o(r0), .resp1_o(r1),
    .resp2_o(r2), .resp3_o(r3)
  );

  localparam logic [11:0] EN = 12'h400, RSP = 12'h040, LNG = 12'h080,
                          IRQ = 12'h100, PND = 12'h200, PRG = 12'h800;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [135:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic f = v[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [47:0] host_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h = {2'b01, idx, arg};
    return {h, crc7({96'd0, h}, 40), 1'b1};
  endfunction

  function automatic logic [47:0] short_resp(input logic [5:0] idx, input logic [31:0] st);
    logic [39:0] h = {2'b00, idx, st};
    return {h, crc7({96'd0, h}, 40), 1'b1};
  endfunction

  function automatic logic [5:0] pvec();
    return {sent, resp_end, crc_fail, tmo, irq_end, prog_done};
  endfunction

  task automatic issue(input logic [11:0] w, input logic [31:0] a);
    @(negedge clk);
    cmd_word = w; cmd_arg = a; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // returns at the negedge where the end bit is on the line
  task automatic grab(output logic [47:0] f, output int oe_cnt);
    int guard = 0;
    f = '0; oe_cnt = 0;
    while (!cmd_oe && guard < 300) begin @(negedge clk); guard++; end
    for (int i = 0; i < 48; i++) begin
      if (i > 0) @(negedge clk);
      f = {f[46:0], cmd_out};
      if (cmd_oe) oe_cnt++;
    end
  endtask

  // first bit driven gap negedges after the end bit; returns at the result negedge
  task automatic respond(input int gap, input logic [135:0] fr, input int len);
    repeat (gap - 1) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      cmd_in = fr[len - 1 - i];
    end
    @(negedge clk);
    cmd_in = 1'b1;
  endtask

  task automatic t_reset();
    chk(!active && !cmd_oe && cmd_out && pvec() == 0, "R11 reset idle", {active, cmd_oe, pvec()}, 0);
    chk(resp_idx == 0 && r0 == 0 && r3 == 0, "R4 reset regs", r0, 0);
  endtask

  task automatic t_no_enable();
    issue(12'h011, 32'h1);
    repeat (5) begin
      @(negedge clk);
      chk(!active && !cmd_oe, "R1 enable clear ignored", {active, cmd_oe}, 0);
    end
  endtask

  task automatic t_cmd0();
    logic [47:0] f; int n;
    issue(EN, 32'h0);
    chk(active, "R11 active at start", active, 1);
    grab(f, n);
    chk(f == 48'h400000000095, "R2 CMD0 frame", f, 48'h400000000095);
    chk(n == 48, "R2 oe length", n, 48);
    @(negedge clk);
    chk(sent && pvec() == 6'b100000, "R3 sent pulse", pvec(), 6'b100000);
    chk(!active && !cmd_oe, "R11 idle after sent", {active, cmd_oe}, 0);
  endtask

  task automatic t_short(input bit bad);
    logic [47:0] f, rf; int n;
    issue(EN | RSP | 12'd17, 32'h0000_1200);
    grab(f, n);
    chk(f == host_frame(6'd17, 32'h0000_1200), "R2 CMD17 frame", f, host_frame(6'd17, 32'h0000_1200));
    rf = short_resp(6'd17, 32'h0000_0900);
    if (bad) rf[3] = ~rf[3];
    respond(3, {88'd0, rf}, 48);
    if (!bad) begin
      chk(pvec() == 6'b010000, "R4 short resp_end", pvec(), 6'b010000);
      chk(resp_idx == 6'd17 && r0 == 32'h0000_0900, "R4 short fields", {resp_idx, r0}, {6'd17, 32'h900});
      chk(r1 == 0 && r2 == 0 && r3 == 0, "R4 other words cleared", {r1, r2}, 0);
      chk(!active, "R11 idle after resp", active, 0);
    end else begin
      chk(pvec() == 6'b001000, "R6 short crc fail", pvec(), 6'b001000);
    end
  endtask

  task automatic t_end_bit_bad();
    logic [47:0] f, rf; int n;
    issue(EN | RSP | 12'd13, 32'h0002_0000);
    grab(f, n);
    rf = short_resp(6'd13, 32'hCAFE_0001);
    rf[0] = 1'b0;
    respond(2, {88'd0, rf}, 48);
    chk(pvec() == 6'b001000, "R6 end bit zero", pvec(), 6'b001000);
  endtask

  task automatic t_long(input bit bad);
    logic [47:0] f; int n;
    logic [119:0] body = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 24'h5A5A5A};
    logic [6:0] c = crc7({16'd0, body}, 120);
    logic [135:0] fr = {2'b00, 6'h3F, body, c, 1'b1};
    if (bad) fr[60] = ~fr[60];
    issue(EN | RSP | LNG | 12'd2, 32'h0);
    grab(f, n);
    respond(5, fr, 136);
    if (!bad) begin
      chk(pvec() == 6'b010000, "R5 long resp_end", pvec(), 6'b010000);
      chk(resp_idx == 6'h3F && r0 == 32'hDEADBEEF, "R5 long word0", {resp_idx, r0}, {6'h3F, 32'hDEADBEEF});
      chk(r1 == 32'h01234567 && r2 == 32'h89ABCDEF, "R5 long word1/2", {r1, r2}, {32'h01234567, 32'h89ABCDEF});
      chk(r3 == {24'h5A5A5A, c, 1'b0}, "R5 long word3", r3, {24'h5A5A5A, c, 1'b0});
    end else begin
      chk(pvec() == 6'b001000, "R6 long crc fail", pvec(), 6'b001000);
    end
  endtask

  task automatic t_timeout();
    logic [47:0] f; int n, k = 0;
    issue(EN | RSP | 12'd9, 32'h0);
    grab(f, n);
    while (!tmo && k < 100) begin @(negedge clk); k++; end
    chk(k == 65, "R7 timeout cycle", k, 65);
    chk(pvec() == 6'b000100 && !active, "R7 timeout pulse", {active, pvec()}, 6'b000100);
  endtask

  task automatic t_late_ok();
    logic [47:0] f; int n;
    issue(EN | RSP | 12'd7, 32'h0);
    grab(f, n);
    respond(64, {88'd0, short_resp(6'd7, 32'h0000_0700)}, 48);
    chk(pvec() == 6'b010000, "R7 start in last window cycle", pvec(), 6'b010000);
  endtask

  task automatic t_pend();
    logic [47:0] f; int n;
    issue(EN | PND | 12'd24, 32'hA5A5_0001);
    repeat (10) begin
      @(negedge clk);
      chk(active && !cmd_oe, "R8 held until pend", {active, cmd_oe}, 2'b10);
    end
    issue(EN | 12'd33, 32'h1111_1111);
    chk(!cmd_oe, "R1 strobe while active", cmd_oe, 0);
    pend = 1'b1;
    grab(f, n);
    pend = 1'b0;
    chk(f == host_frame(6'd24, 32'hA5A5_0001), "R8 R1 frame after pend", f, host_frame(6'd24, 32'hA5A5_0001));
    @(negedge clk);
    chk(pvec() == 6'b100000, "R8 sent after pend", pvec(), 6'b100000);
  endtask

  task automatic t_irq();
    logic [47:0] f; int n, seen = 0;
    issue(EN | RSP | IRQ | 12'd39, 32'h0);
    grab(f, n);
    repeat (100) begin
      @(negedge clk);
      if (pvec() != 0) seen++;
    end
    chk(seen == 0 && active, "R9 no timer", {seen[7:0], active}, 1);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    chk(pvec() == 6'b000010 && !active, "R9 irq end", {active, pvec()}, 6'b000010);
  endtask

  task automatic t_busy();
    logic [47:0] f; int n;
    issue(EN | RSP | PRG | 12'd38, 32'h0);
    grab(f, n);
    dat0 = 1'b0;
    respond(2, {88'd0, short_resp(6'd38, 32'h0000_0E00)}, 48);
    chk(pvec() == 6'b010000 && active, "R10 resp then busy", {active, pvec()}, 7'b1010000);
    repeat (6) begin
      @(negedge clk);
      chk(!prog_done && active, "R10 held while busy", {active, prog_done}, 2'b10);
    end
    dat0 = 1'b1;
    @(negedge clk);
    chk(pvec() == 6'b000001 && !active, "R10 prog done", {active, pvec()}, 6'b000001);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_enable();
    t_cmd0();
    t_short(1'b0);
    t_short(1'b1);
    t_end_bit_bad();
    t_long(1'b0);
    t_long(1'b1);
    t_timeout();
    t_late_ok();
    t_pend();
    t_irq();
    t_busy();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule